// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block steers a DRAM protocol controller between its four operating states: init-memory, config, access and low-power. A requester asks for one of three target states (config, access or low-power). The block reads the controller's reported state and issues single-cycle commands one at a time. The commands are wakeup, cfg, go and sleep. After each command it holds until the reported state shows the expected result. It then decides the next step from the state it now observes. When the observed state equals the target, it pulses `done`.

Each step is chosen again from the live status, not taken from a precomputed route. The path therefore depends only on where the controller actually is. Low-power has to be woken into access before it can enter config. Init-memory has to pass through config on its way to access. A low-power request from init-memory or config always passes through access first.

Top module: `dram_opstate_seq`

## Requirements
- R1: Status codes on `stat_i` are 0 = init-memory, 1 = config, 3 = access and 5 = low-power; every other value is unrecognised. Target codes on `req_target` are 0 = config, 1 = access and 2 = low-power; 3 is reserved. Command codes on `cmd_code` are 0 = wakeup, 1 = cfg, 2 = go and 3 = sleep. In reset and directly after it, `busy`, `done` and `cmd_valid` are low.
- R2: A request is accepted only when `req_valid` is high, `busy` is low and the target is not reserved. `busy` rises on the clock edge that accepts it.
- R3: Each command is a one-cycle `cmd_valid` pulse. No further command is issued until `stat_i` shows the state that the previous command leads to.
- R4: The expected result of each command is as follows. Wakeup leads from low-power to access. Sleep leads from access to low-power. Cfg leads from init-memory or access to config. Go leads from config to access.
- R5: For a config target, the block issues this sequence from each start state:
  - from init-memory: cfg
  - from access: cfg
  - from low-power: wakeup, then cfg
- R6: For an access target, the block issues this sequence from each start state:
  - from init-memory: cfg, then go
  - from config: go
  - from low-power: wakeup
- R7: For a low-power target, the block issues this sequence from each start state:
  - from init-memory: cfg, go, then sleep
  - from config: go, then sleep
  - from access: sleep
- R8: A request for the state already held issues no command. Counting the cycle in which the request is presented as cycle 0, `done` is high in cycle 2.
- R9: While the block is deciding a step and `stat_i` is unrecognised, it issues no command and no `done`. It samples the status again every cycle, and it proceeds once a recognised value appears.
- R10: `done` is a one-cycle pulse, and `busy` is low in the same cycle.
- R11: Requests presented while `busy` is high are ignored. Requests with the reserved target are also ignored. An ignored request changes neither the commands issued nor the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_target | input | 2 | Requested target state code |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: target state reached |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | Command code, valid with `cmd_valid` |
| stat_i | input | 3 | Operating state reported by the controller |

## Verification
Two situations are hard to reach from the ports: a status that is unrecognised at the moment a step is decided, and a second request that lands while one is in flight. The bench models the controller as an agent that applies each command after a chosen delay. It can also force the status to an unused code. With the forced code held across several cycles, the bench first confirms that nothing is issued, then releases it and checks that the correct command follows. A long agent delay keeps a three-step walk busy long enough to inject a competing request in the middle of it. All twelve start/target pairs are then swept from a vector table, using several agent delays.

// File: rtl/opstate_pkg.sv
package opstate_pkg;
  localparam int STAT_W = 3;
  localparam int TGT_W  = 2;
  localparam int CMD_W  = 2;

  localparam logic [STAT_W-1:0] ST_INIT   = 3'd0;
  localparam logic [STAT_W-1:0] ST_CONFIG = 3'd1;
  localparam logic [STAT_W-1:0] ST_ACCESS = 3'd3;
  localparam logic [STAT_W-1:0] ST_LOWPWR = 3'd5;

  localparam logic [TGT_W-1:0] TGT_CONFIG = 2'd0;
  localparam logic [TGT_W-1:0] TGT_ACCESS = 2'd1;
  localparam logic [TGT_W-1:0] TGT_LOWPWR = 2'd2;
  localparam logic [TGT_W-1:0] TGT_RSVD   = 2'd3;

  typedef enum logic [CMD_W-1:0] {
    CMD_WAKE  = 2'd0,
    CMD_CFG   = 2'd1,
    CMD_GO    = 2'd2,
    CMD_SLEEP = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {PH_IDLE, PH_DECIDE, PH_WAIT} phase_e;

  function automatic logic stat_known(input logic [STAT_W-1:0] s);
    return (s == ST_INIT) || (s == ST_CONFIG) || (s == ST_ACCESS) || (s == ST_LOWPWR);
  endfunction

  function automatic logic [STAT_W-1:0] goal_state(input logic [TGT_W-1:0] t);
    case (t)
      TGT_CONFIG: return ST_CONFIG;
      TGT_ACCESS: return ST_ACCESS;
      default:    return ST_LOWPWR;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] cmd_result(input cmd_e c);
    case (c)
      CMD_WAKE:  return ST_ACCESS;
      CMD_CFG:   return ST_CONFIG;
      CMD_GO:    return ST_ACCESS;
      default:   return ST_LOWPWR;
    endcase
  endfunction

  function automatic cmd_e pick_cmd(input logic [STAT_W-1:0] s, input logic [TGT_W-1:0] t);
    cmd_e c;
    c = CMD_CFG;
    case (s)
      ST_LOWPWR: c = CMD_WAKE;
      ST_INIT:   c = CMD_CFG;
      ST_CONFIG: c = CMD_GO;
      ST_ACCESS: c = (t == TGT_LOWPWR) ? CMD_SLEEP : CMD_CFG;
      default:   c = CMD_CFG;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/opstate_step.sv
module opstate_step
  import opstate_pkg::*;
(
  input  logic [STAT_W-1:0] stat,
  input  logic [TGT_W-1:0]  tgt,
  output logic              known,
  output logic              at_goal,
  output cmd_e              step_cmd,
  output logic [STAT_W-1:0] step_expect
);
  always_comb begin
    known       = stat_known(stat);
    at_goal     = known && (stat == goal_state(tgt));
    step_cmd    = pick_cmd(stat, tgt);
    step_expect = cmd_result(step_cmd);
  end
endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TGT_W-1:0]  req_target,
  input  logic [STAT_W-1:0] stat,
  input  logic              known,
  input  logic              at_goal,
  input  cmd_e              step_cmd,
  input  logic [STAT_W-1:0] step_expect,
  output logic [TGT_W-1:0]  tgt_q,
  output phase_e            phase,
  output logic              confirm_hit,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic              done
);
  logic [STAT_W-1:0] expect_q;
  logic              accept;

  assign accept      = (phase == PH_IDLE) && req_valid && (req_target != TGT_RSVD);
  assign confirm_hit = (phase == PH_WAIT) && (stat == expect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      tgt_q     <= TGT_CONFIG;
      expect_q  <= ST_INIT;
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_WAKE;
      done      <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            tgt_q <= req_target;
            phase <= PH_DECIDE;
          end
        end
        PH_DECIDE: begin
          if (known) begin
            if (at_goal) begin
              done  <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              cmd_valid <= 1'b1;
              cmd_code  <= step_cmd;
              expect_q  <= step_expect;
              phase     <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (confirm_hit) phase <= PH_DECIDE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_opstate_seq.sv
module dram_opstate_seq
  import opstate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_target,
  output logic        busy,
  output logic        done,
  output logic        cmd_valid,
  output logic [1:0]  cmd_code,
  input  logic [2:0]  stat_i
);
  logic [TGT_W-1:0]  tgt_q;
  phase_e            phase;
  logic              stat_ok;
  logic              at_goal;
  cmd_e              step_cmd;
  logic [STAT_W-1:0] step_expect;
  logic              confirm_hit;
  cmd_e              cmd_q;
  logic              in_wait;
  logic              in_decide;

  opstate_step u_step (
    .stat(stat_i), .tgt(tgt_q), .known(stat_ok), .at_goal(at_goal),
    .step_cmd(step_cmd), .step_expect(step_expect)
  );

  opstate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .stat(stat_i), .known(stat_ok), .at_goal(at_goal), .step_cmd(step_cmd),
    .step_expect(step_expect), .tgt_q(tgt_q), .phase(phase),
    .confirm_hit(confirm_hit), .cmd_valid(cmd_valid), .cmd_code(cmd_q), .done(done)
  );

  assign cmd_code  = cmd_q;
  assign busy      = (phase != PH_IDLE);
  assign in_wait   = (phase == PH_WAIT);
  assign in_decide = (phase == PH_DECIDE);
endmodule

// File: rtl/opstate_chk.sv
module opstate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic [2:0] stat_i,
  input logic       in_wait,
  input logic       in_decide,
  input logic       confirm_hit,
  input logic       stat_ok
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!busy && !done && !cmd_valid);
  end

  // R2
  busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R3
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R3
  hold_until_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !confirm_hit) |=> !cmd_valid);

  // R4
  wake_from_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'd0) |-> $past(stat_i) == 3'd5);

  // R4
  sleep_from_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'd3) |-> $past(stat_i) == 3'd3);

  // R9
  resample_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decide && !stat_ok) |=> (!cmd_valid && !done && busy));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dram_opstate_seq opstate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_i(stat_i),
  .in_wait(in_wait), .in_decide(in_decide), .confirm_hit(confirm_hit),
  .stat_ok(stat_ok)
);

// File: tb/dram_opstate_seq_tb.sv
module dram_opstate_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_target = 2'd0;
  logic       busy, done, cmd_valid;
  logic [1:0] cmd_code;
  logic [2:0] stat_i;

  logic [2:0] model_st = 3'd0;
  logic       bad_en = 1'b0;
  int         lat = 0;
  logic       pend = 1'b0;
  logic [1:0] pcmd = 2'd0;
  int         pcnt = 0;
  int         ncmd = 0;
  int         ndone = 0;
  logic [1:0] cmd_log [8];
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;
  assign stat_i = bad_en ? 3'd7 : model_st;

  dram_opstate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_i(stat_i)
  );

  function automatic logic [2:0] apply_cmd(input logic [2:0] s, input logic [1:0] c);
    case (c)
      2'd0: return (s == 3'd5) ? 3'd3 : s;
      2'd1: return (s == 3'd0 || s == 3'd3) ? 3'd1 : s;
      2'd2: return (s == 3'd1) ? 3'd3 : s;
      default: return (s == 3'd3) ? 3'd5 : s;
    endcase
  endfunction

  // controller agent and monitor
  always @(negedge clk) begin
    if (pend) begin
      if (pcnt == 0) begin
        model_st = apply_cmd(model_st, pcmd);
        pend = 1'b0;
      end else pcnt = pcnt - 1;
    end
    if (cmd_valid) begin
      pend = 1'b1; pcmd = cmd_code; pcnt = lat;
      if (ncmd < 8) cmd_log[ncmd] = cmd_code;
      ncmd = ncmd + 1;
    end
    if (done) ndone = ndone + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [2:0] st, input logic [1:0] tg, input int lt);
    @(negedge clk);
    model_st = st; lat = lt; ncmd = 0; ndone = 0;
    req_valid = 1'b1; req_target = tg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && ndone == 0; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] goal(input logic [1:0] t);
    return (t == 2'd0) ? 3'd1 : (t == 2'd1) ? 3'd3 : 3'd5;
  endfunction

  // {start[2:0], target[1:0], ncmd[1:0], c0, c1, c2, lat[1:0]}
  localparam logic [14:0] VEC [12] = '{
    {3'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0},
    {3'd3, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2},
    {3'd5, 2'd0, 2'd2, 2'd0, 2'd1, 2'd0, 2'd1},
    {3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {3'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd0, 2'd3},
    {3'd1, 2'd1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0},
    {3'd5, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd2},
    {3'd3, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1},
    {3'd0, 2'd2, 2'd3, 2'd1, 2'd2, 2'd3, 2'd1},
    {3'd1, 2'd2, 2'd2, 2'd2, 2'd3, 2'd0, 2'd3},
    {3'd3, 2'd2, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0},
    {3'd5, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2}
  };

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !cmd_valid, "R1 reset outputs", {busy, done, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !cmd_valid, "R1 after reset", {busy, done, cmd_valid}, 0);

    // R5 R6 R7 R3 R4: sweep of start/target pairs
    for (int v = 0; v < 12; v++) begin
      logic [2:0] st; logic [1:0] tg, n, lt; logic [1:0] ex [3];
      {st, tg, n, ex[0], ex[1], ex[2], lt} = VEC[v];
      kick(st, tg, int'(lt));
      wait_done();
      check(ndone == 1, "R10 single done", ndone, 1);
      check(ncmd == int'(n), "R5/R6/R7 command count", ncmd, int'(n));
      for (int k = 0; k < int'(n) && k < ncmd; k++)
        check(cmd_log[k] == ex[k], "R5/R6/R7 command order", cmd_log[k], ex[k]);
      check(model_st == goal(tg), "R4 final state", model_st, goal(tg));
      repeat (2) @(negedge clk);
    end

    // R8: already in target, done in cycle 2 with no command
    @(negedge clk);
    model_st = 3'd1; ncmd = 0; ndone = 0; req_valid = 1'b1; req_target = 2'd0;
    @(negedge clk); req_valid = 1'b0;
    check(busy && !done, "R8 cycle1 busy, no done", {busy, done}, 2);
    @(negedge clk);
    check(done && !busy, "R8 cycle2 done", {done, busy}, 2);
    check(ncmd == 0, "R8 no command", ncmd, 0);

    // R11: reserved target ignored
    kick(3'd3, 2'd3, 0);
    repeat (4) @(negedge clk);
    check(!busy && ncmd == 0 && ndone == 0, "R11 reserved ignored", ncmd + ndone + int'(busy), 0);
    check(model_st == 3'd3, "R11 state unchanged", model_st, 3);

    // R11: competing request while busy
    kick(3'd0, 2'd2, 3);
    req_valid = 1'b1; req_target = 2'd0;
    @(negedge clk); req_valid = 1'b0;
    wait_done();
    check(ncmd == 3 && ndone == 1, "R11 busy request ignored", ncmd, 3);
    check(model_st == 3'd5, "R11 final low-power", model_st, 5);

    // R9: unrecognised status re-sampled without command
    repeat (2) @(negedge clk);
    bad_en = 1'b1;
    kick(3'd3, 2'd0, 0);
    repeat (5) @(negedge clk);
    check(ncmd == 0 && ndone == 0, "R9 no command on unknown", ncmd, 0);
    check(busy, "R9 still busy", busy, 1);
    bad_en = 1'b0;
    wait_done();
    check(ncmd == 1 && cmd_log[0] == 2'd1, "R9 proceeds with cfg", cmd_log[0], 1);
    check(model_st == 3'd1, "R9 reached config", model_st, 1);

    // R2: acceptance when idle after all of the above
    kick(3'd5, 2'd1, 0);
    check(busy, "R2 busy after accept", busy, 1);
    wait_done();
    check(model_st == 3'd3 && cmd_log[0] == 2'd0, "R2 wake to access", model_st, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule